// File: doc/BRIEF.md
# Keyed Countdown Watchdog

This block is a watchdog timer that sits on a simple 32-bit register bus. A slow tick strobe (nominally 32 kHz) feeds a 9-bit prescaler. Each time the prescaler wraps, a down-counter loaded from a programmable length steps down by one. When the count runs out, the block raises a system reset output for a fixed number of system clocks, reloads the counter and keeps counting. Software keeps the system alive by writing a reload word to the kick register before that happens.

Every write that changes the watchdog's behaviour must carry a key. The mode and length registers each check a key field inside the written word. The kick register and the immediate-reset register act only on one exact 32-bit value. A write with any other value leaves all state as it was. A separate external reset pin copies the reset state at a programmable polarity, or stays at its inactive level when the pin is disabled. Mode bits for interrupt, dual-stage and auto-start operation are stored and read back, but they have no effect in this block.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, sys_rst_o is 0 and ext_rst_o is 1. Offset 0x00 reads 0x00000000. Offset 0x04 reads 0x0000FFE0, which is the largest length, all ones in bits 15:5.
- R2: A write to offset 0x00 is taken only when bits 31:24 of the word are 0x22. Bits 6:0 are then stored, with bit 5 forced to 0. A read returns the stored bits with bits 31:7 at zero. A write with any other key leaves the register unchanged.
- R3: A write to offset 0x04 is taken only when bits 4:0 of the word are 0x08. The length is bits 15:5 of the word. A read returns the length in bits 15:5 and zero elsewhere. A taken length write reloads the counter at once, so the next expiry comes 512×length ticks later.
- R4: Mode bit 0 runs the counter. With the tick held high, sys_rst_o rises exactly 512×length clocks after the enabling write.
- R5: Writing exactly 0x00001971 to offset 0x08 reloads the counter and clears the prescaler. Any other value written there has no effect on when the next expiry comes.
- R6: Writing exactly 0x00001209 to offset 0x14 raises sys_rst_o in the cycle after the write, even when the counter is disabled. Any other value written there does nothing.
- R7: When a keyed mode write clears bit 0, counting stops, and no expiry follows however long the block waits.
- R8: Each reset pulse lasts exactly 16 clocks. After an expiry the counter reloads and keeps running, so expiries repeat every 512×length ticks.
- R9: When mode bit 2 is 1, ext_rst_o is at the level of mode bit 1 while reset is active. At all other times it is at the opposite level.
- R10: Only clocks with tick high advance the prescaler. While tick is low, nothing counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Slow timebase strobe, one count per clock where high |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| sys_rst_o | output | 1 | System reset request, active high |
| ext_rst_o | output | 1 | External reset pin at its programmed polarity |

## Verification
The register keys are tested with a table of write/read pairs. The table has right and wrong keys on both keyed registers, a word with stray bits above the length field, and the reserved mode bit. These pairs show apart key decoding, field extraction and read masking. Expiry timing is measured as an exact clock distance from four different starting events: the enabling write, a length write, a kick write, and the edge where the tick returns. An off-by-one in the prescaler, the counter or the reload shows up as a wrong distance. Wrong kick and reset values, and gaps in the tick, must leave that distance or the reset output unchanged. All three pin settings are checked both idle and during a software reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam logic [7:0]  OFS_MODE   = 8'h00;
    localparam logic [7:0]  OFS_LENGTH = 8'h04;
    localparam logic [7:0]  OFS_KICK   = 8'h08;
    localparam logic [7:0]  OFS_SWRST  = 8'h14;

    localparam logic [7:0]  MODE_KEY   = 8'h22;
    localparam logic [4:0]  LEN_KEY    = 5'h08;
    localparam logic [31:0] KICK_WORD  = 32'h0000_1971;
    localparam logic [31:0] SWRST_WORD = 32'h0000_1209;

    localparam int          LEN_LSB    = 5;
    localparam logic [6:0]  MODE_MASK  = 7'h5F;

    typedef struct packed {
        logic dual;
        logic rsvd;
        logic auto_go;
        logic irq_en;
        logic pin_en;
        logic pin_pol;
        logic run;
    } mode_t;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile #(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              run_o,
    output logic              pin_en_o,
    output logic              pin_pol_o,
    output logic [LEN_W-1:0]  len_next_o,
    output logic              len_load_o,
    output logic              kick_o,
    output logic              swrst_o
);
    import wdt_pkg::*;

    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(OFS_LENGTH);
    localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(OFS_KICK);
    localparam logic [ADDR_W-1:0] A_SWR  = ADDR_W'(OFS_SWRST);

    typedef struct packed {
        mode_t            mode;
        logic [LEN_W-1:0] len;
    } regs_t;

    localparam regs_t REGS_RST = '{mode: '0, len: '1};

    regs_t st_d, st_q;
    logic  wr;

    assign wr = bus_sel_i && bus_we_i;

    always_comb begin
        st_d       = st_q;
        len_load_o = 1'b0;
        kick_o     = 1'b0;
        swrst_o    = 1'b0;
        if (wr) begin
            case (bus_addr_i)
                A_MODE: begin
                    if (bus_wdata_i[31:24] == MODE_KEY)
                        st_d.mode = mode_t'(bus_wdata_i[6:0] & MODE_MASK);
                end
                A_LEN: begin
                    if (bus_wdata_i[4:0] == LEN_KEY) begin
                        st_d.len   = bus_wdata_i[LEN_LSB +: LEN_W];
                        len_load_o = 1'b1;
                    end
                end
                A_KICK:  kick_o  = (bus_wdata_i == KICK_WORD);
                A_SWR:   swrst_o = (bus_wdata_i == SWRST_WORD);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= REGS_RST;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr_i)
            A_MODE:  bus_rdata_o = 32'(st_q.mode);
            A_LEN:   bus_rdata_o = 32'(st_q.len) << LEN_LSB;
            default: bus_rdata_o = '0;
        endcase
    end

    assign run_o      = st_q.mode.run;
    assign pin_en_o   = st_q.mode.pin_en;
    assign pin_pol_o  = st_q.mode.pin_pol;
    assign len_next_o = st_d.len;

    AST_MODE_BADKEY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr_i == A_MODE && bus_wdata_i[31:24] != MODE_KEY) |=> $stable(st_q.mode)); // R2
    AST_LEN_BADKEY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr_i == A_LEN && bus_wdata_i[4:0] != LEN_KEY) |=> $stable(st_q.len)); // R3
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.mode.rsvd); // R2
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int PRE_W = 9,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             reload_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [LEN_W-1:0] cnt;
    } cd_t;

    localparam cd_t CD_RST = '{pre: '0, cnt: '1};

    cd_t  st_d, st_q;
    logic step, wrap;

    assign step     = run_i && tick_i;
    assign wrap     = step && (st_q.pre == '1);
    assign expire_o = wrap && (st_q.cnt <= LEN_W'(1));

    always_comb begin
        st_d = st_q;
        if (reload_i || expire_o) begin
            st_d.cnt = len_i;
            st_d.pre = '0;
        end else if (step) begin
            st_d.pre = st_q.pre + 1'b1;
            if (wrap) st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CD_RST;
        else        st_q <= st_d;
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !reload_i) |=> ($stable(st_q.cnt) && $stable(st_q.pre))); // R7
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (st_q.cnt == $past(len_i) && st_q.pre == '0)); // R5
endmodule

// File: rtl/wdt_rstpulse.sv
module wdt_rstpulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_a_i,
    input  logic fire_b_i,
    output logic active_o
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } pl_t;

    pl_t  st_d, st_q;
    logic fire;

    assign fire = fire_a_i || fire_b_i;

    always_comb begin
        st_d = st_q;
        if (fire)                 st_d.left = PW'(PULSE_LEN);
        else if (st_q.left != '0) st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = (st_q.left != '0);

    AST_FIRE_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> active_o); // R6
    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> $past(fire)); // R8
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
    parameter int ADDR_W    = 8,
    parameter int PRE_W     = 9,
    parameter int LEN_W     = 11,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              sys_rst_o,
    output logic              ext_rst_o
);
    logic             run, pin_en, pin_pol, len_load, kick, swrst, expire;
    logic [LEN_W-1:0] len_next;

    wdt_regfile #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel_i   (bus_sel_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .run_o       (run),
        .pin_en_o    (pin_en),
        .pin_pol_o   (pin_pol),
        .len_next_o  (len_next),
        .len_load_o  (len_load),
        .kick_o      (kick),
        .swrst_o     (swrst)
    );

    wdt_countdown #(.PRE_W(PRE_W), .LEN_W(LEN_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .tick_i   (tick_i),
        .reload_i (len_load || kick),
        .len_i    (len_next),
        .expire_o (expire)
    );

    wdt_rstpulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_a_i (expire),
        .fire_b_i (swrst),
        .active_o (sys_rst_o)
    );

    assign ext_rst_o = (sys_rst_o && pin_en) ? pin_pol : !pin_pol;

    AST_NO_EXPIRE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !expire); // R7
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sys_rst, ext_rst;

    int nchk = 0, nerr = 0;
    int cyc = 0, rise_n = 0, rise_cyc = 0, wr_cyc = 0;
    logic prev_rst = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    keyed_wdt u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .sys_rst_o(sys_rst), .ext_rst_o(ext_rst)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (sys_rst && !prev_rst) begin
            rise_n++;
            rise_cyc = cyc;
        end
        prev_rst = sys_rst;
    end

    // {write, addr, wdata, expected read of addr}
    localparam logic [72:0] VEC [9] = '{
        {1'b1, 8'h00, 32'h2300_0001, 32'h0000_0000},
        {1'b1, 8'h00, 32'h2200_00FE, 32'h0000_005E},
        {1'b1, 8'h00, 32'h11FF_FFFE, 32'h0000_005E},
        {1'b1, 8'h00, 32'h2200_0000, 32'h0000_0000},
        {1'b1, 8'h04, 32'h0000_0048, 32'h0000_0040},
        {1'b1, 8'h04, 32'h0000_0069, 32'h0000_0040},
        {1'b1, 8'h04, 32'hFFFF_0FE8, 32'h0000_0FE0},
        {1'b1, 8'h04, 32'h0000_0048, 32'h0000_0040},
        {1'b0, 8'h08, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bw(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr_cyc = cyc;
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_rise();
        int start = rise_n;
        while (rise_n == start) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    localparam int L = 2;
    localparam int PERIOD = 512 * L;

    initial begin
        logic [31:0] r;
        int t0, n0, w;
        idle(5);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 sys_rst", 32'(sys_rst), 0);
        chk("R1 ext_rst", 32'(ext_rst), 1);
        rd(8'h00, r); chk("R1 mode read", r, 32'h0);
        rd(8'h04, r); chk("R1 length read", r, 32'h0000_FFE0);

        for (int i = 0; i < 9; i++) begin
            if (VEC[i][72]) bw(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], r);
            chk(VEC[i][71:64] == 8'h04 ? "R3 length key vector" : "R2 mode key vector",
                r, VEC[i][31:0]);
        end

        // R4: enable, exact distance to expiry
        bw(8'h00, 32'h2200_0001);
        t0 = wr_cyc;
        wait_rise();
        chk("R4 enable to expiry", 32'(rise_cyc - t0), 32'(PERIOD));

        // R8: pulse width and repeat period
        w = 0;
        while (sys_rst) begin w++; @(negedge clk); #1; end
        chk("R8 pulse width", 32'(w), 16);
        t0 = rise_cyc;
        wait_rise();
        chk("R8 repeat period", 32'(rise_cyc - t0), 32'(PERIOD));

        // R5: kick reloads
        idle(300);
        bw(8'h08, 32'h0000_1971);
        t0 = wr_cyc;
        wait_rise();
        chk("R5 kick reload", 32'(rise_cyc - t0), 32'(PERIOD));
        t0 = rise_cyc;
        idle(300);
        bw(8'h08, 32'h0000_1972);
        wait_rise();
        chk("R5 wrong kick ignored", 32'(rise_cyc - t0), 32'(PERIOD));

        // R3: length write reloads at once
        idle(200);
        bw(8'h04, 32'h0000_0048);
        t0 = wr_cyc;
        wait_rise();
        chk("R3 length write reload", 32'(rise_cyc - t0), 32'(PERIOD));

        // R10: tick low holds the count
        @(negedge clk); tick = 1'b0;
        bw(8'h04, 32'h0000_0048);
        n0 = rise_n;
        idle(1500);
        chk("R10 no count without tick", 32'(rise_n), 32'(n0));
        @(negedge clk);
        t0 = cyc;
        tick = 1'b1;
        wait_rise();
        chk("R10 count resumes with tick", 32'(rise_cyc - t0), 32'(PERIOD));

        // R7: disable stops counting
        while (sys_rst) begin @(negedge clk); #1; end
        bw(8'h00, 32'h2200_0000);
        n0 = rise_n;
        idle(3000);
        chk("R7 disabled no expiry", 32'(rise_n), 32'(n0));

        // R6: software reset
        bw(8'h14, 32'h0000_1209);
        chk("R6 swrst while disabled", 32'(sys_rst), 1);
        idle(20);
        n0 = rise_n;
        bw(8'h14, 32'h0000_1208);
        idle(20); #1;
        chk("R6 wrong swrst ignored", 32'(rise_n), 32'(n0));
        chk("R6 wrong swrst output low", 32'(sys_rst), 0);

        // R9: external pin polarity and enable
        bw(8'h00, 32'h2200_0004);
        chk("R9 low-pol idle", 32'(ext_rst), 1);
        bw(8'h14, 32'h0000_1209);
        chk("R9 low-pol active", 32'(ext_rst), 0);
        idle(20);
        bw(8'h00, 32'h2200_0006);
        chk("R9 high-pol idle", 32'(ext_rst), 0);
        bw(8'h14, 32'h0000_1209);
        chk("R9 high-pol active", 32'(ext_rst), 1);
        idle(20);
        bw(8'h00, 32'h2200_0002);
        bw(8'h14, 32'h0000_1209);
        chk("R9 pin disabled sys_rst", 32'(sys_rst), 1);
        chk("R9 pin disabled stays inactive", 32'(ext_rst), 0);
        idle(20);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule